// File: doc/BRIEF.md
# Duplex-to-Triple Escalating Fault Arbiter

This controller watches three identical copies of a functional element. At any moment two copies are in service and the third is either a powered-down spare or out of service for repair. Each runtime input goes to both in-service copies. A fixed number of cycles later, once the result has propagated through them, the controller compares the two results. When they agree, the result is passed downstream. When they differ, the result is withheld, because either copy or the comparator itself may be wrong.

After a disagreement the controller powers up the spare and judges the next input with a three-way vote. If the spare sides with one in-service copy, the other one is blamed. The blamed copy is taken out of service and a repair request names it, and the spare joins the in-service pair. If both in-service copies agree during the vote, the earlier disagreement is blamed on the comparator: a self-fault flag is raised and the original pair stays in service. A repair-done acknowledge returns the repaired copy to spare duty. A disagreement that arrives while a repair is still open leaves no spare to call on, so the controller raises a sticky unrecoverable flag.

Separately, the controller folds every result it delivers into a running checksum. On request it compares that checksum against an externally held reference and flags a controller integrity fault when they differ.

Top module: `dtmr_arbiter`

## Requirements
- R1: After reset, copies 0 and 1 are in service and copy 2 is a powered-down spare. `role_o` holds 2 bits per copy, copy 0 in the low bits, encoded 00 = spare, 01 = in service, 10 = under repair, so it reads 6'b00_01_01. `wake_o` reads 3'b011. No result is valid, and all flags and the repair request are low.
- R2: An input accepted on `in_valid` at a clock edge is compared PROP_DLY edges later. When the two in-service copies agree, `out_valid` pulses for one cycle with their common value after one further edge.
- R3: When the two in-service copies disagree and a spare exists, no result is delivered for that input, the controller enters the vote, and the spare's bit in `wake_o` goes high.
- R4: During the vote, if the spare matches exactly one in-service copy, the other copy's role becomes under repair, the spare's role becomes in service, and the majority value is delivered.
- R5: Removing a copy raises `repair_req_o` with the copy's index on `repair_id_o`. The request stays high until `repair_ack_i` is seen.
- R6: An acknowledge while a request is open returns the repaired copy to spare and lowers the request. An acknowledge with no open request changes no role.
- R7: If both in-service copies agree during the vote, `self_fault_o` is set and stays set, no role changes, the spare powers down again, and the agreed value is delivered.
- R8: A disagreement while a repair is open delivers nothing and sets `fatal_o`, which stays set. Comparison of the in-service pair carries on.
- R9: Each delivered value updates a checksum: rotate left by one bit, then XOR with the value. A pulse on `chk_strobe_i` sets the sticky `ctrl_fault_o` if the checksum differs from `chk_ref_i`, and clears the checksum.
- R10: Exactly two copies are in service at all times, and `wake_o` is high for in-service copies and, during the vote only, for the spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new input has been applied to the copies |
| copy_out | input | 3*DW | Results of copies 0..2, copy 0 in the low bits |
| out_valid | output | 1 | Delivered result is valid this cycle |
| out_data | output | DW | Delivered result |
| wake_o | output | 3 | Power-up enable per copy |
| role_o | output | 6 | 2-bit role per copy |
| repair_req_o | output | 1 | Repair requested for the named copy |
| repair_id_o | output | 2 | Index of the copy to repair |
| repair_ack_i | input | 1 | Repair finished |
| self_fault_o | output | 1 | Comparator blamed for a disagreement |
| fatal_o | output | 1 | Fault with no spare left |
| chk_strobe_i | input | 1 | Compare the checksum with the reference now |
| chk_ref_i | input | DW | Stored reference checksum |
| ctrl_fault_o | output | 1 | Checksum differed from the reference |

## Verification
The bench drives agreeing inputs, which must flow through with the fixed latency. It drives a single corrupted copy that the spare later outvotes, which separates blaming copy 1 from blaming copy 0 and shows the spare taking over. It drives a disagreement followed by full agreement, which must land on the comparator rather than on a copy. A fault injected while a repair is still open must give the unrecoverable flag instead of a new vote. Matching and corrupted checksum references separate a healthy integrity check from a flagged one.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int NCOPY = 3;

    typedef enum logic [1:0] {
        ROLE_STBY = 2'b00,
        ROLE_ACT  = 2'b01,
        ROLE_RPR  = 2'b10
    } role_t;

    typedef enum logic {
        ST_DUPLEX = 1'b0,
        ST_VOTE   = 1'b1
    } mode_t;

    typedef enum logic [1:0] {
        V_PAIR_OK = 2'd0,
        V_A_BAD   = 2'd1,
        V_B_BAD   = 2'd2,
        V_NO_MAJ  = 2'd3
    } verdict_t;

    typedef struct packed {
        logic [1:0] a;     // lower-index in-service copy
        logic [1:0] b;     // higher-index in-service copy
        logic [1:0] s;     // spare copy
        logic       s_ok;  // a spare exists
    } sel_t;

    function automatic sel_t pick(input role_t r0, input role_t r1, input role_t r2);
        sel_t v;
        v = '0;
        if (r0 == ROLE_ACT) begin
            v.a = 2'd0;
            v.b = (r1 == ROLE_ACT) ? 2'd1 : 2'd2;
        end else begin
            v.a = 2'd1;
            v.b = 2'd2;
        end
        if (r0 == ROLE_STBY) begin
            v.s = 2'd0; v.s_ok = 1'b1;
        end else if (r1 == ROLE_STBY) begin
            v.s = 2'd1; v.s_ok = 1'b1;
        end else if (r2 == ROLE_STBY) begin
            v.s = 2'd2; v.s_ok = 1'b1;
        end
        return v;
    endfunction
endpackage

// File: rtl/dtmr_delay.sv
module dtmr_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] sr;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[DEPTH-2:0], d};
            end
        end
    endgenerate

    assign q = sr[DEPTH-1];
endmodule

// File: rtl/dtmr_vote.sv
module dtmr_vote
    import dtmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] va,
    input  logic [DW-1:0] vb,
    input  logic [DW-1:0] vs,
    output verdict_t      verdict
);
    always_comb begin
        if (va == vb)      verdict = V_PAIR_OK;
        else if (vs == va) verdict = V_B_BAD;
        else if (vs == vb) verdict = V_A_BAD;
        else               verdict = V_NO_MAJ;
    end

    always_comb begin
        if (verdict == V_A_BAD) assert_blame_a_R4: assert (vs == vb && va != vb);
        if (verdict == V_B_BAD) assert_blame_b_R4: assert (vs == va && va != vb);
    end
endmodule

// File: rtl/dtmr_checksum.sv
module dtmr_checksum #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          d_valid,
    input  logic [DW-1:0] d,
    input  logic          strobe,
    input  logic [DW-1:0] ref_sum,
    output logic          fault
);
    logic [DW-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            fault <= 1'b0;
        end else if (strobe) begin
            acc <= '0;
            if (acc != ref_sum) fault <= 1'b1;
        end else if (d_valid) begin
            acc <= {acc[DW-2:0], acc[DW-1]} ^ d;
        end
    end

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);
endmodule

// File: rtl/dtmr_arbiter.sv
module dtmr_arbiter
    import dtmr_pkg::*;
#(
    parameter int DW       = 8,
    parameter int PROP_DLY = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [NCOPY*DW-1:0] copy_out,
    output logic                out_valid,
    output logic [DW-1:0]       out_data,
    output logic [NCOPY-1:0]    wake_o,
    output logic [2*NCOPY-1:0]  role_o,
    output logic                repair_req_o,
    output logic [1:0]          repair_id_o,
    input  logic                repair_ack_i,
    output logic                self_fault_o,
    output logic                fatal_o,
    input  logic                chk_strobe_i,
    input  logic [DW-1:0]       chk_ref_i,
    output logic                ctrl_fault_o
);
    role_t         role_q [NCOPY];
    mode_t         mode_q;
    logic          rep_pend_q;
    logic [1:0]    rep_id_q;
    logic          self_q, fatal_q, out_v_q;
    logic [DW-1:0] out_d_q;
    logic [DW-1:0] cv [NCOPY];
    logic          smp;
    sel_t          sel;
    logic [DW-1:0] va, vb, vs;
    verdict_t      verdict;

    genvar gi;
    generate
        for (gi = 0; gi < NCOPY; gi++) begin : g_copy
            assign cv[gi]       = copy_out[gi*DW +: DW];
            assign role_o[2*gi +: 2] = role_q[gi];
            assign wake_o[gi]   = (role_q[gi] == ROLE_ACT) ||
                                  (mode_q == ST_VOTE && role_q[gi] == ROLE_STBY);
        end
    endgenerate

    dtmr_delay #(.DEPTH(PROP_DLY)) u_dly (
        .clk(clk), .rst(rst), .d(in_valid), .q(smp)
    );

    assign sel = pick(role_q[0], role_q[1], role_q[2]);
    assign va  = cv[sel.a];
    assign vb  = cv[sel.b];
    assign vs  = cv[sel.s];

    dtmr_vote #(.DW(DW)) u_vote (
        .va(va), .vb(vb), .vs(vs), .verdict(verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            role_q[0]  <= ROLE_ACT;
            role_q[1]  <= ROLE_ACT;
            role_q[2]  <= ROLE_STBY;
            mode_q     <= ST_DUPLEX;
            rep_pend_q <= 1'b0;
            rep_id_q   <= 2'd0;
            self_q     <= 1'b0;
            fatal_q    <= 1'b0;
            out_v_q    <= 1'b0;
            out_d_q    <= '0;
        end else begin
            out_v_q <= 1'b0;
            if (repair_ack_i && rep_pend_q) begin
                role_q[rep_id_q] <= ROLE_STBY;
                rep_pend_q       <= 1'b0;
            end
            if (smp) begin
                if (mode_q == ST_DUPLEX) begin
                    if (va == vb) begin
                        out_v_q <= 1'b1;
                        out_d_q <= va;
                    end else if (sel.s_ok) begin
                        mode_q <= ST_VOTE;
                    end else begin
                        fatal_q <= 1'b1;
                    end
                end else begin
                    mode_q <= ST_DUPLEX;
                    case (verdict)
                        V_PAIR_OK: begin
                            self_q  <= 1'b1;
                            out_v_q <= 1'b1;
                            out_d_q <= va;
                        end
                        V_A_BAD: begin
                            role_q[sel.a] <= ROLE_RPR;
                            role_q[sel.s] <= ROLE_ACT;
                            rep_pend_q    <= 1'b1;
                            rep_id_q      <= sel.a;
                            out_v_q       <= 1'b1;
                            out_d_q       <= vb;
                        end
                        V_B_BAD: begin
                            role_q[sel.b] <= ROLE_RPR;
                            role_q[sel.s] <= ROLE_ACT;
                            rep_pend_q    <= 1'b1;
                            rep_id_q      <= sel.b;
                            out_v_q       <= 1'b1;
                            out_d_q       <= va;
                        end
                        default: fatal_q <= 1'b1;
                    endcase
                end
            end
        end
    end

    assign out_valid    = out_v_q;
    assign out_data     = out_d_q;
    assign repair_req_o = rep_pend_q;
    assign repair_id_o  = rep_id_q;
    assign self_fault_o = self_q;
    assign fatal_o      = fatal_q;

    dtmr_checksum #(.DW(DW)) u_sum (
        .clk(clk), .rst(rst), .d_valid(out_v_q), .d(out_d_q),
        .strobe(chk_strobe_i), .ref_sum(chk_ref_i), .fault(ctrl_fault_o)
    );

    assert_mismatch_dropped_R3: assert property (@(posedge clk) disable iff (rst)
        (smp && mode_q == ST_DUPLEX && va != vb) |=> !out_valid);
    assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
        (repair_req_o && !repair_ack_i) |=> (repair_req_o && $stable(repair_id_o)));
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (repair_req_o && repair_ack_i) |=> !repair_req_o);
    assert_self_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        self_fault_o |=> self_fault_o);
    assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        fatal_o |=> fatal_o);
    assert_two_active_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({role_q[0] == ROLE_ACT, role_q[1] == ROLE_ACT,
                    role_q[2] == ROLE_ACT}) == 2);
    assert_wake_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(wake_o) == ((mode_q == ST_VOTE) ? 3 : 2));
endmodule

// File: tb/dtmr_arbiter_test.sv
module dtmr_arbiter_test;
    localparam int DW = 8;
    localparam int PD = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [3*DW-1:0] copy_out;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [2:0]    wake_o;
    logic [5:0]    role_o;
    logic          repair_req_o;
    logic [1:0]    repair_id_o;
    logic          repair_ack_i;
    logic          self_fault_o, fatal_o, ctrl_fault_o;
    logic          chk_strobe_i;
    logic [DW-1:0] chk_ref_i;

    int            n_run = 0;
    int            n_fail = 0;
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] sum_m = '0;

    always #5 clk = ~clk;

    dtmr_arbiter #(.DW(DW), .PROP_DLY(PD)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .copy_out(copy_out),
        .out_valid(out_valid), .out_data(out_data), .wake_o(wake_o),
        .role_o(role_o), .repair_req_o(repair_req_o), .repair_id_o(repair_id_o),
        .repair_ack_i(repair_ack_i), .self_fault_o(self_fault_o),
        .fatal_o(fatal_o), .chk_strobe_i(chk_strobe_i), .chk_ref_i(chk_ref_i),
        .ctrl_fault_o(ctrl_fault_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: every delivered result must match the oldest expected item
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2/R3: got unexpected %0h expected none", out_data);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                if (out_data !== e) begin
                    n_fail++;
                    $display("FAIL R2/R4: got %0h expected %0h", out_data, e);
                end
                sum_m = {sum_m[DW-2:0], sum_m[DW-1]} ^ e;
            end
        end
    end

    // driver: bad < 0 means all copies agree
    task automatic send(input logic [DW-1:0] good, input int bad, input logic deliver);
        @(negedge clk);
        for (int i = 0; i < 3; i++)
            copy_out[i*DW +: DW] = (i == bad) ? ~good : good;
        if (deliver) exp_q.push_back(good);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (PD + 3) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        repair_ack_i = 1'b1;
        @(negedge clk);
        repair_ack_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe(input logic [DW-1:0] r);
        @(negedge clk);
        chk_ref_i    = r;
        chk_strobe_i = 1'b1;
        @(negedge clk);
        chk_strobe_i = 1'b0;
        sum_m        = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; copy_out = '0; repair_ack_i = 1'b0;
        chk_strobe_i = 1'b0; chk_ref_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 role", role_o, 6'b00_01_01);
        check("R1 wake", wake_o, 3'b011);
        check("R1 flags", {out_valid, repair_req_o, self_fault_o, fatal_o, ctrl_fault_o}, 0);

        send(8'h5A, -1, 1'b1);                      // R2 clean pass
        check("R2 role unchanged", role_o, 6'b00_01_01);

        send(8'h33, 1, 1'b0);                       // R3 mismatch dropped
        check("R3 spare woken", wake_o, 3'b111);
        check("R3 queue drained", exp_q.size(), 0);

        send(8'h44, 1, 1'b1);                       // R4 copy 1 outvoted
        check("R4 role", role_o, 6'b01_10_01);
        check("R5 req", repair_req_o, 1'b1);
        check("R5 id", repair_id_o, 2'd1);
        check("R10 wake", wake_o, 3'b101);

        send(8'h77, -1, 1'b1);                      // R4 new pair 0,2 serves
        check("R5 req held", repair_req_o, 1'b1);

        strobe(sum_m);                              // R9 good reference
        check("R9 no fault", ctrl_fault_o, 1'b0);

        ack();                                      // R6
        check("R6 role", role_o, 6'b01_00_01);
        check("R6 req low", repair_req_o, 1'b0);
        ack();                                      // R6 stray ack ignored
        check("R6 stray ack", role_o, 6'b01_00_01);

        send(8'h21, 2, 1'b0);                       // R7 disagreement
        send(8'h90, -1, 1'b1);                      // R7 pair agrees in vote
        check("R7 self fault", self_fault_o, 1'b1);
        check("R7 role", role_o, 6'b01_00_01);
        check("R7 wake", wake_o, 3'b101);
        check("R7 req", repair_req_o, 1'b0);

        send(8'hC3, 0, 1'b0);                       // R4 copy 0 outvoted
        send(8'h18, 0, 1'b1);
        check("R4 role copy0", role_o, 6'b01_01_10);
        check("R5 id copy0", repair_id_o, 2'd0);
        check("R8 no fatal yet", fatal_o, 1'b0);

        send(8'hE7, 2, 1'b0);                       // R8 no spare left
        check("R8 fatal", fatal_o, 1'b1);
        check("R8 role", role_o, 6'b01_01_10);
        send(8'h66, -1, 1'b1);                      // R8 pair still serves
        check("R8 fatal sticky", fatal_o, 1'b1);

        strobe(sum_m ^ 8'h01);                      // R9 wrong reference
        check("R9 fault", ctrl_fault_o, 1'b1);
        check("R2 all delivered", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule